// File: doc/BRIEF.md
# IDE Channel Register Window

This block is the memory-mapped front end of a two-drive IDE channel. It occupies a 4 KiB address window on a simple bus that carries an address, an access size of 1, 2 or 4 bytes, separate read and write strobes, write data and combinational read data. The byte address is split into 16-byte slots. Each slot honours only certain access sizes. Accesses to the data port, the task-file registers and the status/device-control slots are forwarded to an abstract IDE core port as single-cycle strobes. Each strobe carries a kind, a register index and a size, and the core answers a read in the same cycle.

The block also holds two registers of its own: a 32-bit drive-timing word and a 32-bit interrupt status word. Two interrupt lines enter the block, line 0 for DMA and line 1 for the disk. Both are passed straight through to outputs. Each line is also reflected in the status word at bit 31 minus its line number. The DMA bit is edge-driven and software can clear it. The disk bit is a live image of its line. Any read that no rule accepts returns all ones, and any write that no rule accepts is dropped. Data is little-endian, so the low byte sits in bits 7:0.

Top module: `ide_mmio_window`

## Requirements
- R1: The slot index is the byte address shifted right by 4. Address bits 3:0 have no effect on any access.
- R2: Slot 0 (data port) accepts reads of size 1, 2 and 4. Each raises `coreRd` with `coreKind`=0 and `coreIdx`=0. Sizes 1 and 2 request `coreSize`=2 and size 4 requests `coreSize`=4. A 1-byte read returns `coreRdata[7:0]` zero-extended, a 2-byte read returns `coreRdata[15:0]` zero-extended, and a 4-byte read returns all of `coreRdata`.
- R3: Slot 0 forwards writes of size 2 and 4 only: `coreWr`, `coreKind`=0, `coreSize` equal to the bus size and `coreWdata` equal to the bus write data. A 1-byte write to slot 0 raises no strobe.
- R4: Slots 1 to 7 (task file) accept only 1-byte accesses. These appear on the core port with `coreKind`=1, `coreIdx` equal to the slot number and `coreSize`=1. A read returns `coreRdata[7:0]` zero-extended.
- R5: Slots 0x08 and 0x16 both map to status on read and device control on write. Both accept only 1-byte accesses, which use `coreKind`=2, `coreIdx`=0 and `coreSize`=1. A read returns `coreRdata[7:0]` zero-extended.
- R6: Status bit 31 is set on the clock after a rising edge of `irqIn[0]` and cleared on the clock after a falling edge. A 4-byte write to slot 0x30 with bit 31 set clears it, and other write bits have no effect on it. A rising edge in the same cycle as that write leaves the bit set.
- R7: Status bit 30 equals `irqIn[1]` as sampled at the previous clock edge, and a write never changes it. Status bits 29:0 read as zero.
- R8: Slot 0x20 is a 32-bit timing register that is read and written only with 4-byte accesses.
- R9: A read that no rule accepts returns 0xFFFFFFFF and raises no core strobe. A write that no rule accepts changes no register and raises no core strobe.
- R10: `irqOut` equals `irqIn` combinationally.
- R11: Reset clears the timing register and the interrupt status word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address within the window |
| busSize | input | 3 | Access size in bytes (1, 2 or 4) |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data, little-endian |
| busRdata | output | 32 | Read data, valid in the strobe cycle |
| coreRd | output | 1 | Forwarded read strobe |
| coreWr | output | 1 | Forwarded write strobe |
| coreKind | output | 2 | 0 data port, 1 task file, 2 status/control |
| coreIdx | output | 3 | Task-file register number |
| coreSize | output | 3 | Forwarded access size in bytes |
| coreWdata | output | 32 | Forwarded write data |
| coreRdata | input | 32 | Core read data, same cycle |
| irqIn | input | 2 | Interrupt lines: bit 0 DMA, bit 1 disk |
| irqOut | output | 2 | Pass-through of the interrupt lines |

## Verification
The assertions assume that the interrupt lines are low while reset is held. Without that, the disk-bit comparison against the previous sample would see a line that the status word could not follow during reset. They also assume that a read and a write are never strobed in the same cycle. The stimulus keeps `irqIn` at zero around every reset, drives only one strobe per access, and changes inputs only on the falling clock edge. The sweep covers every slot of the window with every size from 1 to 4, both as reads and as writes, and the interrupt sequence is run separately.

// File: rtl/ide_win_pkg.sv
`timescale 1ns/1ps
package ide_win_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;

  typedef enum logic [1:0] {
    CORE_DATA = 2'd0,
    CORE_TASK = 2'd1,
    CORE_STAT = 2'd2
  } coreKind_e;

  typedef enum logic [2:0] {
    RD_ONES,
    RD_CORE8,
    RD_CORE16,
    RD_CORE32,
    RD_TIMING,
    RD_IRQ
  } rdSel_e;

  // strobes from the slot decoder to the datapath
  typedef struct packed {
    logic             coreRd;
    logic             coreWr;
    coreKind_e        kind;
    logic [IDX_W-1:0] idx;
    logic [2:0]       size;
    logic             timingWr;
    logic             irqWr;
    rdSel_e           rdSel;
  } winCtl_t;
endpackage

// File: rtl/ide_win_ctl.sv
`timescale 1ns/1ps
module ide_win_ctl
  import ide_win_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int STRIDE_LOG2 = 4,
  parameter int TASK_LAST   = 7,
  parameter int SLOT_STAT   = 'h08,
  parameter int SLOT_ALT    = 'h16,
  parameter int SLOT_TIMING = 'h20,
  parameter int SLOT_IRQ    = 'h30
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic              busRd,
  input  logic              busWr,
  output winCtl_t           ctl
);
  localparam int SLOT_W = ADDR_W - STRIDE_LOG2;

  logic [SLOT_W-1:0] slot;
  logic sz1, sz2, sz4;
  logic isTask, isStat;

  assign slot   = busAddr[ADDR_W-1:STRIDE_LOG2];
  assign sz1    = (busSize == 3'd1);
  assign sz2    = (busSize == 3'd2);
  assign sz4    = (busSize == 3'd4);
  assign isTask = (slot >= SLOT_W'(1)) && (slot <= SLOT_W'(TASK_LAST));
  assign isStat = (slot == SLOT_W'(SLOT_STAT)) || (slot == SLOT_W'(SLOT_ALT));

  always_comb begin
    ctl       = '0;
    ctl.kind  = CORE_DATA;
    ctl.rdSel = RD_ONES;
    if (slot == '0) begin
      if (busRd && (sz1 || sz2 || sz4)) begin
        ctl.coreRd = 1'b1;
        ctl.size   = sz4 ? 3'd4 : 3'd2;
        ctl.rdSel  = sz1 ? RD_CORE8 : (sz2 ? RD_CORE16 : RD_CORE32);
      end
      if (busWr && (sz2 || sz4)) begin
        ctl.coreWr = 1'b1;
        ctl.size   = busSize;
      end
    end else if (isTask && sz1) begin
      ctl.coreRd = busRd;
      ctl.coreWr = busWr;
      ctl.kind   = CORE_TASK;
      ctl.idx    = slot[IDX_W-1:0];
      ctl.size   = 3'd1;
      if (busRd) ctl.rdSel = RD_CORE8;
    end else if (isStat && sz1) begin
      ctl.coreRd = busRd;
      ctl.coreWr = busWr;
      ctl.kind   = CORE_STAT;
      ctl.size   = 3'd1;
      if (busRd) ctl.rdSel = RD_CORE8;
    end else if (slot == SLOT_W'(SLOT_TIMING) && sz4) begin
      ctl.timingWr = busWr;
      if (busRd) ctl.rdSel = RD_TIMING;
    end else if (slot == SLOT_W'(SLOT_IRQ) && sz4) begin
      ctl.irqWr = busWr;
      if (busRd) ctl.rdSel = RD_IRQ;
    end
  end
endmodule

// File: rtl/ide_win_data.sv
`timescale 1ns/1ps
module ide_win_data
  import ide_win_pkg::*;
#(
  parameter int               IRQ_N      = 2,
  parameter logic [IRQ_N-1:0] LATCH_MASK = 2'b01
) (
  input  logic              clk,
  input  logic              rstN,
  input  winCtl_t           ctl,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] coreRdata,
  input  logic [IRQ_N-1:0]  irqIn,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] timingQ,
  output logic [DATA_W-1:0] irqQ
);
  logic [IRQ_N-1:0] lineQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timingQ <= '0;
    else if (ctl.timingWr) timingQ <= busWdata;
  end

  for (genvar n = 0; n < IRQ_N; n++) begin : gLine
    if (LATCH_MASK[n]) begin : gLatch
      logic prevQ, bitQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prevQ <= 1'b0;
          bitQ  <= 1'b0;
        end else begin
          prevQ <= irqIn[n];
          if (irqIn[n] && !prevQ)                      bitQ <= 1'b1;
          else if (!irqIn[n] && prevQ)                 bitQ <= 1'b0;
          else if (ctl.irqWr && busWdata[DATA_W-1-n])  bitQ <= 1'b0;
        end
      end
      assign lineQ[n] = bitQ;
    end else begin : gLive
      logic bitQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bitQ <= 1'b0;
        else       bitQ <= irqIn[n];
      end
      assign lineQ[n] = bitQ;
    end
  end

  always_comb begin
    irqQ = '0;
    for (int n = 0; n < IRQ_N; n++) irqQ[DATA_W-1-n] = lineQ[n];
  end

  always_comb begin
    unique case (ctl.rdSel)
      RD_CORE8:  busRdata = {{(DATA_W-8){1'b0}}, coreRdata[7:0]};
      RD_CORE16: busRdata = {{(DATA_W-16){1'b0}}, coreRdata[15:0]};
      RD_CORE32: busRdata = coreRdata;
      RD_TIMING: busRdata = timingQ;
      RD_IRQ:    busRdata = irqQ;
      default:   busRdata = '1;
    endcase
  end
endmodule

// File: rtl/ide_mmio_window.sv
`timescale 1ns/1ps
module ide_mmio_window
  import ide_win_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IRQ_N  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              coreRd,
  output logic              coreWr,
  output logic [1:0]        coreKind,
  output logic [2:0]        coreIdx,
  output logic [2:0]        coreSize,
  output logic [31:0]       coreWdata,
  input  logic [31:0]       coreRdata,
  input  logic [IRQ_N-1:0]  irqIn,
  output logic [IRQ_N-1:0]  irqOut
);
  winCtl_t           ctl;
  logic [DATA_W-1:0] timingQ;
  logic [DATA_W-1:0] irqQ;

  ide_win_ctl #(.ADDR_W(ADDR_W)) uCtl (
    .busAddr(busAddr), .busSize(busSize), .busRd(busRd), .busWr(busWr), .ctl(ctl)
  );

  ide_win_data #(.IRQ_N(IRQ_N), .LATCH_MASK(IRQ_N'(1))) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busWdata(busWdata), .coreRdata(coreRdata),
    .irqIn(irqIn), .busRdata(busRdata), .timingQ(timingQ), .irqQ(irqQ)
  );

  assign coreRd    = ctl.coreRd;
  assign coreWr    = ctl.coreWr;
  assign coreKind  = ctl.kind;
  assign coreIdx   = ctl.idx;
  assign coreSize  = ctl.size;
  assign coreWdata = busWdata;
  assign irqOut    = irqIn;
endmodule

// File: rtl/ide_mmio_window_chk.sv
`timescale 1ns/1ps
module ide_mmio_window_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [2:0]        busSize,
  input logic              busRd,
  input logic              busWr,
  input logic [31:0]       busRdata,
  input logic              coreRd,
  input logic [1:0]        irqIn,
  input logic [1:0]        irqOut,
  input logic [31:0]       timingQ,
  input logic [31:0]       irqQ
);
  logic badSize, timingHit;
  assign badSize   = !(busSize == 3'd1 || busSize == 3'd2 || busSize == 3'd4);
  assign timingHit = busWr && (busAddr[ADDR_W-1:4] == (ADDR_W-4)'('h20)) && (busSize == 3'd4);

  assert_dma_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqIn[0]) |=> irqQ[31]);
  assert_dma_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqIn[0]) |=> !irqQ[31]);
  assert_disk_live_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqQ[30] == $past(irqIn[1]));
  assert_spare_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqQ[29:0] == 30'd0);
  assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && badSize) |-> (busRdata == 32'hFFFF_FFFF && !coreRd));
  assert_core_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> !coreRd);
  assert_timing_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !timingHit |=> $stable(timingQ));
  assert_irq_pass_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == irqIn);
endmodule

bind ide_mmio_window ide_mmio_window_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busSize(busSize), .busRd(busRd),
  .busWr(busWr), .busRdata(busRdata), .coreRd(coreRd), .irqIn(irqIn),
  .irqOut(irqOut), .timingQ(timingQ), .irqQ(irqQ)
);

// File: tb/sim_ide_mmio_window.sv
`timescale 1ns/1ps
module sim_ide_mmio_window;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic [2:0]  busSize = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        coreRd, coreWr;
  logic [1:0]  coreKind;
  logic [2:0]  coreIdx, coreSize;
  logic [31:0] coreWdata;
  logic [31:0] coreRdata = '0;
  logic [1:0]  irqIn = '0;
  logic [1:0]  irqOut;

  int nChk = 0;
  int nFail = 0;
  logic [31:0] expTim = '0;

  always #4 clk = ~clk;

  ide_mmio_window u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busSize(busSize), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .coreRd(coreRd),
    .coreWr(coreWr), .coreKind(coreKind), .coreIdx(coreIdx), .coreSize(coreSize),
    .coreWdata(coreWdata), .coreRdata(coreRdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one access at the falling edge; outputs are valid 1 ns later
  task automatic access(logic rd, logic wr, int slot, int nib, int sz, logic [31:0] d);
    @(negedge clk);
    busRd = rd; busWr = wr;
    busAddr = 12'((slot << 4) | (nib & 15));
    busSize = 3'(sz); busWdata = d;
    coreRdata = 32'h9E37_79B9 ^ 32'(slot * 32'h0101_0101);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0;
    #1;
  endtask

  function automatic logic isCoreSlot(int slot);
    return (slot >= 1 && slot <= 7) || slot == 'h08 || slot == 'h16;
  endfunction

  function automatic string reqOf(int slot);
    if (slot == 0) return "R2/R3";
    if (slot >= 1 && slot <= 7) return "R4";
    if (slot == 'h08 || slot == 'h16) return "R5";
    if (slot == 'h20) return "R8";
    return "R9";
  endfunction

  task automatic readExpect(string tag, int slot, logic [31:0] exp);
    access(1'b1, 1'b0, slot, 0, 4, '0);
    chk(tag, busRdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 core strobes idle in reset", {30'd0, coreRd, coreWr}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    readExpect("R11 timing after reset", 'h20, 32'd0);
    readExpect("R11 irq status after reset", 'h30, 32'd0);

    // read sweep over every slot and size
    for (int slot = 0; slot < 256; slot++) begin
      for (int sz = 1; sz <= 4; sz++) begin
        logic [31:0] core, expData;
        logic expRd;
        logic [1:0] expKind;
        logic [2:0] expIdx, expSize;
        access(1'b1, 1'b0, slot, slot * 5 + sz, sz, '0);
        core = coreRdata;
        expData = 32'hFFFF_FFFF; expRd = 1'b0; expKind = 2'd0; expIdx = 3'd0; expSize = 3'd0;
        if (slot == 0 && sz != 3) begin
          expRd = 1'b1; expSize = (sz == 4) ? 3'd4 : 3'd2;
          expData = (sz == 1) ? {24'd0, core[7:0]} : (sz == 2) ? {16'd0, core[15:0]} : core;
        end else if (isCoreSlot(slot) && sz == 1) begin
          expRd = 1'b1; expSize = 3'd1; expData = {24'd0, core[7:0]};
          expKind = (slot <= 7) ? 2'd1 : 2'd2;
          expIdx = (slot <= 7) ? 3'(slot) : 3'd0;
        end else if (slot == 'h20 && sz == 4) begin
          expData = 32'd0;
        end else if (slot == 'h30 && sz == 4) begin
          expData = 32'd0;
        end
        chk({reqOf(slot), " R1 read data"}, busRdata, expData);
        chk({reqOf(slot), " read core strobe"},
            {23'd0, expRd ? {coreKind, coreIdx, coreSize} : 8'd0, coreRd},
            {23'd0, expRd ? {expKind, expIdx, expSize} : 8'd0, expRd});
      end
    end

    // write sweep; timing read back after each write
    for (int slot = 0; slot < 256; slot++) begin
      for (int sz = 1; sz <= 4; sz++) begin
        logic [31:0] d;
        logic expWr;
        logic [1:0] expKind;
        logic [2:0] expIdx, expSize;
        d = 32'h3C00_0000 ^ 32'(slot * 32'h0001_0203 + sz);
        access(1'b0, 1'b1, slot, slot + sz, sz, d);
        expWr = 1'b0; expKind = 2'd0; expIdx = 3'd0; expSize = 3'd0;
        if (slot == 0 && (sz == 2 || sz == 4)) begin
          expWr = 1'b1; expSize = 3'(sz);
        end else if (isCoreSlot(slot) && sz == 1) begin
          expWr = 1'b1; expSize = 3'd1;
          expKind = (slot <= 7) ? 2'd1 : 2'd2;
          expIdx = (slot <= 7) ? 3'(slot) : 3'd0;
        end
        if (slot == 'h20 && sz == 4) expTim = d;
        chk({reqOf(slot), " write core strobe"},
            {23'd0, expWr ? {coreKind, coreIdx, coreSize} : 8'd0, coreWr},
            {23'd0, expWr ? {expKind, expIdx, expSize} : 8'd0, expWr});
        if (expWr) chk("R3 forwarded write data", coreWdata, d);
        readExpect({reqOf(slot), " timing after write"}, 'h20, expTim);
      end
    end
    idle();
    access(1'b1, 1'b0, 'h20, 15, 4, '0);
    chk("R1 low address bits ignored", busRdata, expTim);
    readExpect("R7 status untouched by sweep", 'h30, 32'd0);

    // DMA line behaviour
    @(negedge clk); irqIn = 2'b01; #1;
    chk("R10 pass-through dma", {30'd0, irqOut}, 32'd1);
    readExpect("R6 dma rise sets bit31", 'h30, 32'h8000_0000);
    access(1'b0, 1'b1, 'h30, 0, 2, 32'hFFFF_FFFF);
    readExpect("R9 short write to status ignored", 'h30, 32'h8000_0000);
    access(1'b0, 1'b1, 'h30, 0, 4, 32'h7FFF_FFFF);
    readExpect("R6 clear needs bit31", 'h30, 32'h8000_0000);
    access(1'b0, 1'b1, 'h30, 0, 4, 32'h8000_0000);
    readExpect("R6 clear while line high", 'h30, 32'd0);
    readExpect("R6 stays clear without edge", 'h30, 32'd0);
    @(negedge clk); irqIn = 2'b00;
    readExpect("R6 fall keeps clear", 'h30, 32'd0);
    access(1'b0, 1'b1, 'h30, 0, 4, 32'h8000_0000);
    irqIn = 2'b01;
    readExpect("R6 rise beats clear", 'h30, 32'h8000_0000);
    @(negedge clk); irqIn = 2'b00;
    readExpect("R6 fall clears bit31", 'h30, 32'd0);

    // disk line behaviour
    @(negedge clk); irqIn = 2'b10; #1;
    chk("R10 pass-through disk", {30'd0, irqOut}, 32'd2);
    readExpect("R7 disk bit30 follows", 'h30, 32'h4000_0000);
    access(1'b0, 1'b1, 'h30, 0, 4, 32'hC000_0000);
    readExpect("R7 write leaves bit30", 'h30, 32'h4000_0000);
    @(negedge clk); irqIn = 2'b11;
    readExpect("R6 R7 both lines", 'h30, 32'hC000_0000);
    @(negedge clk); irqIn = 2'b00;
    readExpect("R7 disk bit30 drops", 'h30, 32'd0);

    // reset clears registers
    access(1'b0, 1'b1, 'h20, 0, 4, 32'h1234_5678);
    readExpect("R8 timing written", 'h20, 32'h1234_5678);
    @(negedge clk); irqIn = 2'b01;
    idle(); idle();
    @(negedge clk); irqIn = 2'b00; busRd = 1'b0; busWr = 1'b0; rstN = 1'b0;
    idle();
    @(negedge clk); rstN = 1'b1;
    readExpect("R11 timing cleared by reset", 'h20, 32'd0);
    readExpect("R11 status cleared by reset", 'h30, 32'd0);
    idle();

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule